// File: doc/BRIEF.md
# Byte-Wide Stack and Scratchpad Unit

This unit holds the on-chip data scratchpad of a small 8-bit controller core, together with the hardware stack pointer that walks through it. On each clock it carries out at most one operation chosen by a 3-bit code. The operations are push, pop, a read or write through a pointer register of the selected bank, a read or write at a direct address, and a load of the stack pointer. It does no instruction decoding and no arithmetic apart from stepping the pointer.

The parameter `RAM_BYTES` picks a 128-byte or a 256-byte array. A direct address with bit 7 set never reaches the array. It goes out on a separate special-register port, so the upper 128 bytes can only be reached through a pointer register or through the stack. Nothing guards the stack against overflow or underflow. The pointer is 8 bits and wraps freely.

Top module: `stack_scratchpad`

## Requirements
- R1: While reset is asserted and after its release, `sp` reads 07h and `rdData` reads 00h until the first operation completes.
- R2: Push (opCode 1) sets `sp` to `sp`+1 in the next cycle and writes `wrData` to the byte that the new pointer value addresses. The first push after reset therefore lands at 08h.
- R3: Pop (opCode 2) returns the byte at the current `sp` on `rdData` in the next cycle and lowers `sp` by one.
- R4: Load-pointer (opCode 7) copies `operand` into `sp` in the next cycle. Any value is accepted.
- R5: A push from `sp`=FFh wraps the pointer to 00h and writes the byte to location 00h, which is bank-0 pointer register 0. No flag is raised.
- R6: Indirect read (opCode 3) and indirect write (opCode 4) use, as their address, the byte held at location `bankSel`×8 + `operand[0]`. `operand[0]`=0 picks pointer register 0 and 1 picks pointer register 1.
- R7: Direct read (opCode 5) and direct write (opCode 6) with `operand[7]`=0 access the array byte at `operand`.
- R8: A direct read or write with `operand[7]`=1 raises `sfrRdEn` or `sfrWrEn` in the same cycle, with `sfrAddr`=`operand` and `sfrWrData`=`wrData`. The array is not touched, and a read returns the sampled `sfrRdData` in the next cycle. No other operation raises either enable.
- R9: Every read returns its data on the cycle after the request. A read issued on the cycle right after a write to the same byte returns the new value.
- R10: With `RAM_BYTES`=128, any stack or indirect access whose address is 80h or higher returns 00h on a read and leaves the array unchanged on a write.
- R11: No-op (opCode 0) and the write operations leave `rdData` unchanged. Only push, pop and load-pointer change `sp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 indirect read, 4 indirect write, 5 direct read, 6 direct write, 7 load pointer |
| operand | input | 8 | Direct address, pointer-register select (bit 0), or new pointer value |
| bankSel | input | 2 | Register bank that holds the pointer registers |
| wrData | input | 8 | Byte to write or push |
| sfrRdData | input | 8 | Read data returned by the special-register space |
| rdData | output | 8 | Registered read result |
| sp | output | 8 | Current stack pointer |
| sfrAddr | output | 8 | Special-register address |
| sfrRdEn | output | 1 | Special-register read strobe |
| sfrWrEn | output | 1 | Special-register write strobe |
| sfrWrData | output | 8 | Special-register write data |

## Verification
The assertions check the pointer movement on every cycle: a step up on push, a step down on pop, a copy on load, and no change otherwise. They also check that `rdData` holds steady on operations that are not reads, and that the special-register strobes follow the direct address and return their data. Only the bench scenarios can show what the array holds. This covers where a push lands, the wrap into bank 0, the pointer registers resolved per bank, read-after-write of the same byte, and the zero-read and dropped-write behaviour of the 128-byte variant. The bench checks these against a reference model for both array sizes.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_RDIND = 3'd3,
    OP_WRIND = 3'd4,
    OP_RDDIR = 3'd5,
    OP_WRDIR = 3'd6,
    OP_LDSP  = 3'd7
  } spadOp_e;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic push;
    logic pop;
    logic indRd;
    logic indWr;
    logic dirRd;
    logic dirWr;
    logic sfrRd;
    logic sfrWr;
    logic loadSp;
  } spadStrobe_t;

  localparam logic [7:0] SP_RESET = 8'h07;

endpackage

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
(
  input  logic [2:0]  opCode,
  input  logic        dirHigh,
  output spadStrobe_t strobe
);

  spadOp_e op;
  assign op = spadOp_e'(opCode);

  always_comb begin
    strobe = '0;
    unique case (op)
      OP_PUSH:  strobe.push   = 1'b1;
      OP_POP:   strobe.pop    = 1'b1;
      OP_RDIND: strobe.indRd  = 1'b1;
      OP_WRIND: strobe.indWr  = 1'b1;
      OP_RDDIR: begin
        strobe.dirRd = !dirHigh;
        strobe.sfrRd = dirHigh;
      end
      OP_WRDIR: begin
        strobe.dirWr = !dirHigh;
        strobe.sfrWr = dirHigh;
      end
      OP_LDSP:  strobe.loadSp = 1'b1;
      default:  strobe = '0;
    endcase
  end

endmodule

// File: rtl/spad_datapath.sv
module spad_datapath
  import spad_pkg::*;
#(
  parameter int RAM_BYTES = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  spadStrobe_t strobe,
  input  logic [7:0]  operand,
  input  logic [1:0]  bankSel,
  input  logic [7:0]  wrData,
  input  logic [7:0]  sfrRdData,
  output logic [7:0]  rdData,
  output logic [7:0]  spOut
);

  localparam int         IDX_W = $clog2(RAM_BYTES);
  localparam logic [8:0] LIMIT = 9'(RAM_BYTES);

  logic [7:0] mem [RAM_BYTES];
  logic [7:0] spQ;
  logic [7:0] rdQ;

  logic [7:0] spInc;
  logic [7:0] ptrIdx;
  logic [7:0] ptrVal;
  logic [7:0] ramAddr;
  logic       inRange;
  logic [7:0] ramRdByte;
  logic       ramWrEn;

  assign spInc  = spQ + 8'd1;
  // pointer register of the active bank: bank*8 + select
  assign ptrIdx = {3'b000, bankSel, 2'b00, operand[0]};
  assign ptrVal = mem[IDX_W'(ptrIdx)];

  always_comb begin
    if (strobe.push)                      ramAddr = spInc;
    else if (strobe.pop)                  ramAddr = spQ;
    else if (strobe.indRd || strobe.indWr) ramAddr = ptrVal;
    else                                  ramAddr = operand;
  end

  generate
    if (RAM_BYTES >= 256) begin : g_full
      assign inRange = 1'b1;
    end else begin : g_half
      assign inRange = ({1'b0, ramAddr} < LIMIT);
    end
  endgenerate

  assign ramRdByte = inRange ? mem[ramAddr[IDX_W-1:0]] : 8'h00;
  assign ramWrEn   = (strobe.push || strobe.indWr || strobe.dirWr) && inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_BYTES; i++) mem[i] <= 8'h00;
    end else if (ramWrEn) begin
      mem[ramAddr[IDX_W-1:0]] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ <= SP_RESET;
    end else if (strobe.push) begin
      spQ <= spInc;
    end else if (strobe.pop) begin
      spQ <= spQ - 8'd1;
    end else if (strobe.loadSp) begin
      spQ <= operand;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= 8'h00;
    end else if (strobe.pop || strobe.indRd || strobe.dirRd) begin
      rdQ <= ramRdByte;
    end else if (strobe.sfrRd) begin
      rdQ <= sfrRdData;
    end
  end

  assign rdData = rdQ;
  assign spOut  = spQ;

endmodule

// File: rtl/stack_scratchpad.sv
module stack_scratchpad
  import spad_pkg::*;
#(
  parameter int RAM_BYTES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opCode,
  input  logic [7:0] operand,
  input  logic [1:0] bankSel,
  input  logic [7:0] wrData,
  input  logic [7:0] sfrRdData,
  output logic [7:0] rdData,
  output logic [7:0] sp,
  output logic [7:0] sfrAddr,
  output logic       sfrRdEn,
  output logic       sfrWrEn,
  output logic [7:0] sfrWrData
);

  spadStrobe_t strobe;

  spad_ctrl u_ctrl (
    .opCode  (opCode),
    .dirHigh (operand[7]),
    .strobe  (strobe)
  );

  spad_datapath #(.RAM_BYTES(RAM_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .operand   (operand),
    .bankSel   (bankSel),
    .wrData    (wrData),
    .sfrRdData (sfrRdData),
    .rdData    (rdData),
    .spOut     (sp)
  );

  assign sfrAddr   = operand;
  assign sfrRdEn   = strobe.sfrRd;
  assign sfrWrEn   = strobe.sfrWr;
  assign sfrWrData = wrData;

endmodule

// File: rtl/spad_checker.sv
module spad_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] opCode,
  input logic [7:0] operand,
  input logic [7:0] sfrRdData,
  input logic [7:0] rdData,
  input logic [7:0] sp,
  input logic       sfrRdEn,
  input logic       sfrWrEn
);

  logic isDirHigh;
  logic isRead;
  logic movesSp;
  assign isDirHigh = (opCode == 3'd5 || opCode == 3'd6) && operand[7];
  assign isRead    = (opCode == 3'd2 || opCode == 3'd3 || opCode == 3'd5);
  assign movesSp   = (opCode == 3'd1 || opCode == 3'd2 || opCode == 3'd7);

  assert_reset_sp_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (sp == 8'h07 && rdData == 8'h00));

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd1 |=> sp == 8'($past(sp) + 8'd1));

  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd2 |=> sp == 8'($past(sp) - 8'd1));

  assert_load_sp_R4: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd7 |=> sp == $past(operand));

  assert_sp_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !movesSp |=> $stable(sp));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> $stable(rdData));

  assert_sfr_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd5 && operand[7]) |-> (sfrRdEn && !sfrWrEn));

  assert_sfr_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd6 && operand[7]) |-> (sfrWrEn && !sfrRdEn));

  assert_sfr_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !isDirHigh |-> (!sfrRdEn && !sfrWrEn));

  assert_sfr_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd5 && operand[7]) |=> rdData == $past(sfrRdData));

endmodule

bind stack_scratchpad spad_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opCode    (opCode),
  .operand   (operand),
  .sfrRdData (sfrRdData),
  .rdData    (rdData),
  .sp        (sp),
  .sfrRdEn   (sfrRdEn),
  .sfrWrEn   (sfrWrEn)
);

// File: tb/sim_stack_scratchpad.sv
module sim_stack_scratchpad;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opIn = 3'd0;
  logic [7:0] operandIn = 8'h00;
  logic [1:0] bankIn = 2'd0;
  logic [7:0] dataIn = 8'h00;

  logic [7:0] rd0, sp0, sfrA0, sfrWd0, sfrRd0;
  logic       sfrRe0, sfrWe0;
  logic [7:0] rd1, sp1, sfrA1, sfrWd1, sfrRd1;
  logic       sfrRe1, sfrWe1;

  int total = 0;
  int fails = 0;

  logic [7:0] refMem [2][256];
  logic [7:0] refSp [2];
  logic [7:0] refRd [2];

  always #4 clk = ~clk;

  // special-register space model: read value derived from address
  assign sfrRd0 = sfrA0 ^ 8'h3C;
  assign sfrRd1 = sfrA1 ^ 8'h3C;

  stack_scratchpad #(.RAM_BYTES(256)) u0 (
    .clk(clk), .rstN(rstN), .opCode(opIn), .operand(operandIn),
    .bankSel(bankIn), .wrData(dataIn), .sfrRdData(sfrRd0),
    .rdData(rd0), .sp(sp0), .sfrAddr(sfrA0), .sfrRdEn(sfrRe0),
    .sfrWrEn(sfrWe0), .sfrWrData(sfrWd0)
  );

  stack_scratchpad #(.RAM_BYTES(128)) u1 (
    .clk(clk), .rstN(rstN), .opCode(opIn), .operand(operandIn),
    .bankSel(bankIn), .wrData(dataIn), .sfrRdData(sfrRd1),
    .rdData(rd1), .sp(sp1), .sfrAddr(sfrA1), .sfrRdEn(sfrRe1),
    .sfrWrEn(sfrWe1), .sfrWrData(sfrWd1)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic chkEq(input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
    end
  endtask

  function automatic string reqFor(input logic [2:0] o, input logic [7:0] a);
    case (o)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R6";
      3'd5, 3'd6: return a[7] ? "R8" : "R7";
      3'd7: return "R4";
      default: return "R11";
    endcase
  endfunction

  function automatic logic inRam(input int cfg, input logic [7:0] addr);
    return (cfg == 0) || (addr < 8'h80);
  endfunction

  task automatic modelStep(input logic [2:0] o, input logic [7:0] a,
                           input logic [1:0] b, input logic [7:0] d);
    for (int cfg = 0; cfg < 2; cfg++) begin
      logic [7:0] ptr;
      ptr = refMem[cfg][{3'b000, b, 2'b00, a[0]}];
      case (o)
        3'd1: begin
          refSp[cfg] = refSp[cfg] + 8'd1;
          if (inRam(cfg, refSp[cfg])) refMem[cfg][refSp[cfg]] = d;
        end
        3'd2: begin
          refRd[cfg] = inRam(cfg, refSp[cfg]) ? refMem[cfg][refSp[cfg]] : 8'h00;
          refSp[cfg] = refSp[cfg] - 8'd1;
        end
        3'd3: refRd[cfg] = inRam(cfg, ptr) ? refMem[cfg][ptr] : 8'h00;
        3'd4: if (inRam(cfg, ptr)) refMem[cfg][ptr] = d;
        3'd5: refRd[cfg] = a[7] ? (a ^ 8'h3C) : refMem[cfg][a];
        3'd6: if (!a[7]) refMem[cfg][a] = d;
        3'd7: refSp[cfg] = a;
        default: ;
      endcase
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic doOp(input logic [2:0] o, input logic [7:0] a,
                      input logic [1:0] b, input logic [7:0] d);
    string tag;
    tag = reqFor(o, a);
    opIn = o; operandIn = a; bankIn = b; dataIn = d;
    modelStep(o, a, b, d);
    #1;
    chkEq("R8", "sfr read strobe", {7'd0, sfrRe0}, {7'd0, (o == 3'd5) && a[7]});
    chkEq("R8", "sfr write strobe", {7'd0, sfrWe0}, {7'd0, (o == 3'd6) && a[7]});
    if (sfrWe0) chkEq("R8", "sfr write data", sfrWd0, d);
    @(posedge clk);
    @(negedge clk);
    chkEq(tag, "sp (256)", sp0, refSp[0]);
    chkEq(tag, "rdData (256)", rd0, refRd[0]);
    chkEq(tag, "sp (128)", sp1, refSp[1]);
    chkEq(tag, "rdData (128)", rd1, refRd[1]);
    opIn = 3'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int i = 0; i < 256; i++) refMem[cfg][i] = 8'h00;
      refSp[cfg] = 8'h07;
      refRd[cfg] = 8'h00;
    end
    repeat (3) @(negedge clk);
    chkEq("R1", "sp in reset", sp0, 8'h07);
    chkEq("R1", "rdData in reset", rd0, 8'h00);
    chkEq("R1", "sp in reset (128)", sp1, 8'h07);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "sp after release", sp0, 8'h07);

    // first push lands just above bank 0
    doOp(3'd1, 8'h00, 2'd0, 8'hA5);
    chkEq("R2", "pointer after first push", sp0, 8'h08);
    doOp(3'd5, 8'h08, 2'd0, 8'h00);
    chkEq("R2", "byte at 08h", rd0, 8'hA5);
    doOp(3'd2, 8'h00, 2'd0, 8'h00);
    chkEq("R3", "popped byte", rd0, 8'hA5);
    chkEq("R3", "pointer after pop", sp0, 8'h07);

    // write then read the same byte on back-to-back cycles
    doOp(3'd6, 8'h40, 2'd0, 8'h77);
    doOp(3'd5, 8'h40, 2'd0, 8'h00);
    chkEq("R9", "read after write", rd0, 8'h77);

    // bank 2 pointer register 1 points into the upper half
    doOp(3'd6, 8'h11, 2'd0, 8'hC0);
    doOp(3'd4, 8'h01, 2'd2, 8'h5E);
    doOp(3'd3, 8'h01, 2'd2, 8'h00);
    chkEq("R6", "indirect via bank2 ptr1", rd0, 8'h5E);
    chkEq("R10", "upper indirect read (128)", rd1, 8'h00);
    doOp(3'd3, 8'h00, 2'd2, 8'h00);
    chkEq("R6", "indirect via bank2 ptr0", rd0, 8'h00);

    // wrap from FFh into bank-0 register 0
    doOp(3'd7, 8'hFF, 2'd0, 8'h00);
    doOp(3'd1, 8'h00, 2'd0, 8'h99);
    chkEq("R5", "pointer wraps", sp0, 8'h00);
    doOp(3'd5, 8'h00, 2'd0, 8'h00);
    chkEq("R5", "wrapped push at 00h", rd0, 8'h99);
    chkEq("R5", "wrapped push at 00h (128)", rd1, 8'h99);

    // 128-byte variant drops stack traffic above 7Fh
    doOp(3'd7, 8'h7F, 2'd0, 8'h00);
    doOp(3'd1, 8'h00, 2'd0, 8'h12);
    doOp(3'd2, 8'h00, 2'd0, 8'h00);
    chkEq("R10", "stack above 7Fh (256)", rd0, 8'h12);
    chkEq("R10", "stack above 7Fh (128)", rd1, 8'h00);

    // direct upper addresses go to the special-register port
    doOp(3'd5, 8'h9A, 2'd0, 8'h00);
    chkEq("R8", "special read data", rd0, 8'h9A ^ 8'h3C);
    doOp(3'd6, 8'hC0, 2'd0, 8'h33);
    doOp(3'd3, 8'h01, 2'd2, 8'h00);
    chkEq("R8", "RAM C0h untouched by direct write", rd0, 8'h5E);
    doOp(3'd0, 8'h00, 2'd0, 8'h00);
    chkEq("R11", "no-op holds rdData", rd0, 8'h5E);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] o;
      logic [7:0] a;
      o = 3'($urandom_range(0, 7));
      a = 8'($urandom);
      if (o == 3'd6 && ($urandom_range(0, 3) == 0)) a = 8'($urandom_range(0, 31));
      doOp(o, a, 2'($urandom), 8'($urandom));
    end

    summary();
    $finish;
  end

endmodule